// File: doc/BRIEF.md
# Concatenable Eight-Channel PWM Generator

The block produces eight left-aligned pulse-width modulated outputs from one input clock. Software reaches it through a small register port: an enable byte with one bit per channel, a pair-join nibble, and a period and a duty byte for every channel. All channels share one 3-bit prescaler. The prescaler's tick, once every eight clocks, marks the start of a channel clock cycle. Every channel counter steps once per tick. When none of the eight enable bits is set, the prescaler is held at zero.

Adjacent channels 2k and 2k+1 can be joined into one 16-bit channel. In joined mode the even channel supplies the high byte of the counter, the period and the duty. The odd channel supplies the low byte. The odd channel's enable bit alone starts and stops the 16-bit channel, and its output line carries the waveform. The even channel's enable bit is ignored and its output line stays low. Period and duty writes are shadowed and reach a running waveform only when its period wraps, so no cycle is ever cut short or stretched.

Top module: `pwm_octet`

## Requirements
- R1: Register map: address 0 is the enable byte (bit n enables channel n), address 1 is the pair-join nibble (bit k joins channels 2k and 2k+1), address 8+n is channel n's period and address 16+n is channel n's duty. All registers reset to zero and can be written and read back at any time.
- R2: A newly enabled channel starts at the next prescaler tick, not at the write. When the prescaler is already running for other channels, the output rises right after the shared tick.
- R3: Clearing a channel's enable bit forces its output low from the cycle after the write. Its counter restarts from zero when it is enabled again.
- R4: When join bit k is set, channels 2k and 2k+1 form one 16-bit channel. It is driven on output line 2k+1 and is enabled only by enable bit 2k+1.
- R5: While join bit k is set, enable bit 2k has no effect and output line 2k stays low.
- R6: While all enable bits are clear, the prescaler is held at zero. The first tick after an enable from idle therefore comes eight clocks after the write edge, so the output is first high at the ninth falling edge following it.
- R7: With period P and duty D, counted in ticks of eight clocks, the output is high for the first D ticks of every P-tick period and low for the rest. D = 0 gives a constant low output, and D >= P gives a constant high output.
- R8: Period and duty writes to a running channel take effect only at its next period wrap.
- R9: In joined mode the period is {period[2k], period[2k+1]} and the duty is {duty[2k], duty[2k+1]}, with the even channel's byte as the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| pwm_out | output | 8 | PWM output lines, one per channel |

## Verification
The hardest case to reach is a duty write that lands in the middle of a running period, because the shadow registers hide it until the period wraps. The bench first locks onto a period start by waiting for the output's rising edge. It then issues the write a fixed number of clocks later, inside the sampling loop itself, and counts high clocks in the current period and in the next one separately. Prescaler alignment gets the same treatment: a second channel is enabled two clocks after a known tick, and its first rising edge must land on the shared tick rather than eight clocks after the write.

// File: rtl/pwm_octet_pkg.sv
package pwm_octet_pkg;
  // Channel byte width; a joined pair counts over twice this width.
  localparam int unsigned DW = 8;
  localparam int unsigned CW = 2 * DW;

  typedef logic [CW-1:0] cnt_t;

  // True when the counter has reached the last step of its period.
  // Period values 0 and 1 both give a one-tick period.
  function automatic logic pwm_wrap(input cnt_t cnt, input cnt_t per);
    logic [CW:0] nxt;
    nxt = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    return nxt >= {1'b0, per};
  endfunction

  // Left-aligned level: high while the count is below the duty.
  function automatic logic pwm_level(input cnt_t cnt, input cnt_t duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/pwm_octet_regs.sv
module pwm_octet_regs
  import pwm_octet_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic [NCH-1:0]          en,
  output logic [NCH/2-1:0]        pair_join,
  output logic [NCH-1:0][DW-1:0]  per,
  output logic [NCH-1:0][DW-1:0]  duty
);
  localparam int IW = $clog2(NCH);
  localparam int NP = NCH / 2;
  localparam int GW = AW - IW;
  localparam logic [GW-1:0] G_CTL  = GW'(0);
  localparam logic [GW-1:0] G_PER  = GW'(1);
  localparam logic [GW-1:0] G_DUTY = GW'(2);

  logic [GW-1:0] grp;
  logic [IW-1:0] idx;
  assign grp = addr[AW-1:IW];
  assign idx = addr[IW-1:0];

  // Named decode events for the assertions.
  logic wr_en_byte;
  assign wr_en_byte = we && (grp == G_CTL) && (idx == IW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      pair_join <= '0;
      per       <= '0;
      duty      <= '0;
    end else if (we) begin
      case (grp)
        G_CTL: begin
          if (idx == IW'(0))      en        <= wdata[NCH-1:0];
          else if (idx == IW'(1)) pair_join <= wdata[NP-1:0];
        end
        G_PER:   per[idx]  <= wdata;
        G_DUTY:  duty[idx] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (grp)
      G_CTL: begin
        if (idx == IW'(0))      rdata = DW'(en);
        else if (idx == IW'(1)) rdata = DW'(pair_join);
      end
      G_PER:   rdata = per[idx];
      G_DUTY:  rdata = duty[idx];
      default: rdata = '0;
    endcase
  end

  // R1: an enable write is visible in the next cycle.
  p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_byte |=> (en == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/pwm_octet_prescale.sv
module pwm_octet_prescale #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == '1);

  // R6: with no channel enabled the divider sits at zero.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R2: ticks never come back to back.
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pwm_octet_pair.sv
module pwm_octet_pair
  import pwm_octet_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_e,
  input  logic          en_o,
  input  logic          pair_join,
  input  logic [DW-1:0] per_e,
  input  logic [DW-1:0] per_o,
  input  logic [DW-1:0] duty_e,
  input  logic [DW-1:0] duty_o,
  output logic          out_e,
  output logic          out_o
);
  logic          run_e, run_o, join_q;
  logic [DW-1:0] cnt_e, cnt_o;
  logic [DW-1:0] sh_per_e, sh_per_o, sh_duty_e, sh_duty_o;

  // Internal events, named for the assertions.
  logic join_chg, en_e_eff;
  logic wrap_e, wrap_o, wrap_16;
  cnt_t cnt_16, per_16, duty_16;

  assign join_chg = pair_join ^ join_q;
  assign en_e_eff = en_e & ~pair_join;
  assign cnt_16   = {cnt_e, cnt_o};
  assign per_16   = {sh_per_e, sh_per_o};
  assign duty_16  = {sh_duty_e, sh_duty_o};
  assign wrap_e   = pwm_wrap(cnt_t'(cnt_e), cnt_t'(sh_per_e));
  assign wrap_o   = pwm_wrap(cnt_t'(cnt_o), cnt_t'(sh_per_o));
  assign wrap_16  = pwm_wrap(cnt_16, per_16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_e <= 1'b0; run_o <= 1'b0; join_q <= 1'b0;
      cnt_e <= '0;   cnt_o <= '0;
      sh_per_e  <= '0; sh_per_o  <= '0;
      sh_duty_e <= '0; sh_duty_o <= '0;
    end else begin
      join_q <= pair_join;
      if (join_chg) begin
        // Mode change: both halves restart cleanly.
        run_e <= 1'b0; run_o <= 1'b0;
        cnt_e <= '0;   cnt_o <= '0;
      end else if (pair_join) begin
        run_e <= 1'b0;
        if (!en_o) begin
          run_o <= 1'b0;
          cnt_e <= '0; cnt_o <= '0;
        end else if (tick) begin
          if (!run_o || wrap_16) begin
            run_o <= 1'b1;
            {cnt_e, cnt_o} <= '0;
            sh_per_e  <= per_e;  sh_per_o  <= per_o;
            sh_duty_e <= duty_e; sh_duty_o <= duty_o;
          end else begin
            {cnt_e, cnt_o} <= cnt_16 + 1'b1;
          end
        end
      end else begin
        if (!en_o) begin
          run_o <= 1'b0;
          cnt_o <= '0;
        end else if (tick) begin
          if (!run_o || wrap_o) begin
            run_o <= 1'b1;
            cnt_o <= '0;
            sh_per_o <= per_o; sh_duty_o <= duty_o;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        if (!en_e_eff) begin
          run_e <= 1'b0;
          cnt_e <= '0;
        end else if (tick) begin
          if (!run_e || wrap_e) begin
            run_e <= 1'b1;
            cnt_e <= '0;
            sh_per_e <= per_e; sh_duty_e <= duty_e;
          end else begin
            cnt_e <= cnt_e + 1'b1;
          end
        end
      end
    end
  end

  assign out_e = en_e_eff & run_e & pwm_level(cnt_t'(cnt_e), cnt_t'(sh_duty_e));
  assign out_o = en_o & run_o &
                 (pair_join ? pwm_level(cnt_16, duty_16)
                            : pwm_level(cnt_t'(cnt_o), cnt_t'(sh_duty_o)));

  // R5: the high-order line of a joined pair stays low.
  p_even_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_join |-> !out_e);

  // R2: a channel only starts running on a prescaler tick.
  p_start_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(tick));

  // R3: a disabled channel drives low.
  p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !out_o);

  // R8: shadow settings change only on a tick.
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(sh_duty_o) && $stable(sh_per_o)));
endmodule

// File: rtl/pwm_octet.sv
module pwm_octet
  import pwm_octet_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 5,
  parameter int PW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int NP = NCH / 2;

  logic [NCH-1:0]         en;
  logic [NP-1:0]          pj;
  logic [NCH-1:0][DW-1:0] per, duty;
  logic                   any_en, tick;

  pwm_octet_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk, .rst_n,
    .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .en(en), .pair_join(pj), .per(per), .duty(duty)
  );

  assign any_en = |en;

  pwm_octet_prescale #(.PW(PW)) u_pre (
    .clk, .rst_n, .run(any_en), .tick(tick)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    pwm_octet_pair u_pair (
      .clk, .rst_n, .tick(tick),
      .en_e(en[2*p]), .en_o(en[2*p+1]), .pair_join(pj[p]),
      .per_e(per[2*p]), .per_o(per[2*p+1]),
      .duty_e(duty[2*p]), .duty_o(duty[2*p+1]),
      .out_e(pwm_out[2*p]), .out_o(pwm_out[2*p+1])
    );
  end
endmodule

// File: tb/pwm_octet_test.sv
module pwm_octet_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pwm_out;

  int tests = 0;
  int failed = 0;

  localparam int A_EN = 0, A_JOIN = 1, A_PER = 8, A_DUTY = 16;

  always #5 clk = ~clk;

  pwm_octet uut (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .pwm_out
  );

  task automatic check_eq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write.
  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 5'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
  endtask

  task automatic wait_rise(input int ch, output int idx);
    idx = 1;
    while (pwm_out[ch] !== 1'b1 && idx < 5000) begin
      @(negedge clk);
      idx++;
    end
  endtask

  task automatic count_two(input int a, input int b, input int n,
                           output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[a]) ha++;
      if (pwm_out[b]) hb++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int d;
    check_eq("R1 outputs low after reset", int'(pwm_out), 0);
    rd(A_EN, d);   check_eq("R1 enable resets to zero", d, 0);
    rd(A_JOIN, d); check_eq("R1 join resets to zero", d, 0);
  endtask

  task automatic t_regs();
    int d;
    wr(A_EN, 8'hA5);   rd(A_EN, d);       check_eq("R1 enable readback", d, 8'hA5);
    wr(A_EN, 0);
    wr(A_JOIN, 8'h0F); rd(A_JOIN, d);     check_eq("R1 join readback", d, 8'h0F);
    wr(A_JOIN, 0);
    wr(A_PER + 6, 8'h3C); rd(A_PER + 6, d); check_eq("R1 period readback", d, 8'h3C);
    wr(A_DUTY + 7, 8'h5A); rd(A_DUTY + 7, d); check_eq("R1 duty readback", d, 8'h5A);
  endtask

  task automatic t_start_idle();
    int idx, h, x;
    wr(A_PER + 1, 4); wr(A_DUTY + 1, 2);
    repeat (4) @(negedge clk);
    wr(A_EN, 8'h02);
    wait_rise(1, idx);
    check_eq("R6 first high after idle enable", idx, 9);
    count_two(1, 0, 32, h, x);
    check_eq("R7 duty 2 of period 4", h, 16);
    wr(A_EN, 0);
    check_eq("R3 output low right after disable", int'(pwm_out[1]), 0);
    count_two(1, 0, 40, h, x);
    check_eq("R3 stays low while disabled", h, 0);
    repeat (100) @(negedge clk);
    wr(A_EN, 8'h02);
    wait_rise(1, idx);
    check_eq("R6 prescaler restarts from zero", idx, 9);
    count_two(1, 0, 32, h, x);
    check_eq("R3 counter restarts from zero", h, 16);
  endtask

  task automatic t_duty_edges();
    int idx, h, x;
    wr(A_EN, 0); wr(A_DUTY + 1, 0); wr(A_EN, 8'h02);
    count_two(1, 0, 100, h, x);
    check_eq("R7 duty 0 constant low", h, 0);
    wr(A_EN, 0); wr(A_DUTY + 1, 5); wr(A_EN, 8'h02);
    wait_rise(1, idx);
    count_two(1, 0, 64, h, x);
    check_eq("R7 duty above period constant high", h, 64);
  endtask

  task automatic t_shadow();
    int idx, h1, h2;
    wr(A_EN, 0); wr(A_PER + 1, 4); wr(A_DUTY + 1, 1); wr(A_EN, 8'h02);
    wait_rise(1, idx);
    h1 = 0; h2 = 0;
    for (int i = 0; i < 64; i++) begin
      if (pwm_out[1]) begin
        if (i < 32) h1++; else h2++;
      end
      if (i == 10) begin
        bus_we = 1'b1; bus_addr = 5'(A_DUTY + 1); bus_wdata = 8'd3;
      end
      if (i == 11) bus_we = 1'b0;
      @(negedge clk);
    end
    check_eq("R8 old duty holds until wrap", h1, 8);
    check_eq("R8 new duty after wrap", h2, 24);
  endtask

  task automatic t_shared_tick();
    int idx;
    wr(A_EN, 0); wr(A_PER + 0, 4); wr(A_DUTY + 0, 2);
    wr(A_DUTY + 1, 3); wr(A_EN, 8'h02);
    wait_rise(1, idx);
    repeat (2) @(negedge clk);
    wr(A_EN, 8'h03);
    wait_rise(0, idx);
    check_eq("R2 second channel starts on shared tick", idx, 6);
  endtask

  task automatic t_join();
    int idx, h3, h2;
    wr(A_EN, 0);
    wr(A_PER + 2, 8'h01); wr(A_PER + 3, 8'h00);
    wr(A_DUTY + 2, 8'h00); wr(A_DUTY + 3, 8'h80);
    wr(A_JOIN, 8'h02);
    wr(A_EN, 8'h0C);
    wait_rise(3, idx);
    check_eq("R4 joined channel starts on odd line", idx, 9);
    count_two(3, 2, 2048, h3, h2);
    check_eq("R9 joined 16-bit duty over 16-bit period", h3, 1024);
    check_eq("R5 even line low while joined", h2, 0);
    wr(A_EN, 8'h04);
    count_two(3, 2, 200, h3, h2);
    check_eq("R4 even enable alone leaves joined channel off", h3, 0);
    check_eq("R5 even enable ignored while joined", h2, 0);
    wr(A_JOIN, 0); wr(A_EN, 0);
  endtask

  task automatic t_separate_pair();
    int idx, h4, h5;
    wr(A_PER + 4, 3); wr(A_DUTY + 4, 1);
    wr(A_PER + 5, 6); wr(A_DUTY + 5, 3);
    repeat (3) @(negedge clk);
    wr(A_EN, 8'h30);
    wait_rise(4, idx);
    count_two(4, 5, 48, h4, h5);
    check_eq("R7 channel 4 duty 1 of 3", h4, 16);
    check_eq("R7 channel 5 duty 3 of 6", h5, 24);
    wr(A_EN, 0);
  endtask

  initial begin
    #(200000 * 10);
    tests++;
    failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_start_idle();
    t_duty_edges();
    t_shadow();
    t_shared_tick();
    t_join();
    t_separate_pair();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule